// File: doc/BRIEF.md
# Pipelined Load-Store Execute Unit

This block is the memory execute unit of an in-order-issue integer core. It takes decoded byte, halfword and word loads and stores, each with resolved operands, and turns them into word-aligned requests on a valid/ready memory port. Load results return to a valid/ready writeback port together with the instruction's tags. The unit has two stages. The first stage holds incoming instructions in a small input FIFO. That FIFO passes an entry straight through when it is empty. The first stage adds base and offset, aligns the address, and places store data and byte strobes in the correct lanes. The second stage pairs each memory response with the metadata of the request that caused it. It then picks the addressed bytes, extends them, and presents the result for writeback.

The memory returns one response per request, stores included, in request order. Several requests may be outstanding. Their metadata waits in a queue whose depth is the in-flight parameter rounded up to a power of two. One more request is held in a stage-2 register. The stage-2 slot is a two-state machine. `S2_IDLE` means no response is awaited. `S2_WAIT` means the slot holds the metadata of the oldest outstanding request. The transitions are:
- `T_BYPASS` (IDLE to WAIT): a request issues while the queue is empty, and its metadata is written straight into the slot.
- `T_CHAIN` (WAIT to WAIT): a response is consumed and the slot is refilled in the same cycle, from the queue head or from a request issued in that cycle.
- `T_DRAIN` (WAIT to IDLE): a response is consumed and nothing is left to load.
- `T_HOLD` (WAIT to WAIT): no response is consumed.

Micro-op codes on `in_op` are: 0 LB, 1 LH, 2 LW, 3 LBU, 4 LHU, 5 SB, 6 SH, 7 SW.

Top module: `lsu_pipe`

## Requirements
- R1: `mreq_addr` equals `in_base + in_ofs` with bits [1:0] cleared. The low two bits of that sum are the byte offset.
- R2: Strobes and store data depend on the micro-op:
  - SB gives strobe `4'b0001 << offset` and places `in_sdata[7:0]` in byte lane `offset`.
  - SH gives strobe `4'b0011 << offset` and places `in_sdata[15:0]` starting at lane `offset`.
  - SW gives strobe `4'b1111` with the data unchanged.
  - Loads give strobe `4'b0000`.
  - `mreq_we` is 1 for codes 5 to 7 and 0 otherwise.
- R3: `mreq_val` is high only when an instruction is at the input head and the metadata queue has space. The queue depth QDEPTH is MAX_INFLIGHT rounded up to a power of two. With the defaults, at most QDEPTH+1 = 5 requests are outstanding.
- R4: When the input FIFO is empty and the request side can issue, an instruction presented on `in_val` issues in that same cycle. While issue is stalled, the FIFO accepts IN_DEPTH (2) further instructions and then drops `in_rdy`.
- R5: A request accepted while nothing is outstanding moves the slot to `S2_WAIT` in the next cycle. With one-cycle memory latency and writeback always ready, each result leaves one cycle after its request was accepted.
- R6: Load results are taken from the response word shifted right by 8×offset:
  - LB and LH sign-extend bits [7:0] and [15:0].
  - LBU and LHU zero-extend them.
  - LW passes all 32 bits.
- R7: Stores complete with `wb_wen` = 0 and `wb_data` = 0. Loads complete with `wb_wen` = 1.
- R8: Results leave in request order. `wb_seq`, `wb_dst`, `wb_preg` and `wb_ppreg` carry the values that arrived with the instruction.
- R9: `mrsp_rdy` is high only when the slot is in `S2_WAIT` and `wb_rdy` is high. `wb_val` is high only when `mrsp_val` is high in the same cycle.
- R10: During and after reset, with no input, `in_rdy` = 1 and `mreq_val`, `mrsp_rdy` and `wb_val` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_val | input | 1 | Instruction valid from issue |
| in_rdy | output | 1 | Input FIFO can accept |
| in_op | input | 3 | Micro-op code |
| in_seq | input | SEQ_W | Sequence number |
| in_dst | input | AREG_W | Architectural destination |
| in_preg | input | PREG_W | Physical destination |
| in_ppreg | input | PREG_W | Previous physical mapping |
| in_base | input | DATA_W | Base operand |
| in_ofs | input | DATA_W | Offset operand |
| in_sdata | input | DATA_W | Store data |
| mreq_val | output | 1 | Memory request valid |
| mreq_rdy | input | 1 | Memory accepts request |
| mreq_we | output | 1 | Request is a write |
| mreq_addr | output | DATA_W | Word-aligned address |
| mreq_wdata | output | DATA_W | Lane-aligned write data |
| mreq_strb | output | DATA_W/8 | Byte write strobes |
| mrsp_val | input | 1 | Memory response valid |
| mrsp_rdy | output | 1 | Unit accepts response |
| mrsp_data | input | DATA_W | Response word |
| wb_val | output | 1 | Result valid |
| wb_rdy | input | 1 | Writeback accepts |
| wb_seq | output | SEQ_W | Sequence number |
| wb_dst | output | AREG_W | Architectural destination |
| wb_preg | output | PREG_W | Physical destination |
| wb_ppreg | output | PREG_W | Previous physical mapping |
| wb_wen | output | 1 | Register write enable |
| wb_data | output | DATA_W | Extended load data |

## Verification
The bench targets three kinds of fault: byte lanes, sign extension, and ordering.

- **Byte lanes.** It uses every byte offset for byte loads, the upper-half offset for halfword loads and stores, and a negative offset that crosses a word boundary. A wrong strobe or lane shift would corrupt the memory model, so a later load reads the wrong byte. A wrong extension shows up as a flipped upper half.
- **Backpressure.** It withholds responses until the request side stalls. The outstanding count must be exactly QDEPTH+1, and `in_rdy` must drop after two more instructions. A queue counted one entry short or long, or a slot that skipped the bypass, changes those counts.
- **Ordering.** It runs the same sequence under random-like ready patterns and longer latency. Metadata paired with the wrong response would appear as a wrong tag or wrong data. A bypass that cost an extra cycle would break the one-cycle turnaround check.

// File: rtl/lsu_pkg.sv
`timescale 1ns/1ps
package lsu_pkg;

    typedef enum logic [2:0] {
        OP_LB  = 3'd0,
        OP_LH  = 3'd1,
        OP_LW  = 3'd2,
        OP_LBU = 3'd3,
        OP_LHU = 3'd4,
        OP_SB  = 3'd5,
        OP_SH  = 3'd6,
        OP_SW  = 3'd7
    } lsu_op_e;

    typedef enum logic {
        S2_IDLE = 1'b0,
        S2_WAIT = 1'b1
    } s2_state_e;

    function automatic logic op_is_store(lsu_op_e op);
        return (op == OP_SB) || (op == OP_SH) || (op == OP_SW);
    endfunction

endpackage

// File: rtl/lsu_fifo.sv
`timescale 1ns/1ps
module lsu_fifo #(
    parameter int W      = 8,
    parameter int DEPTH  = 2,
    parameter bit BYPASS = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_val,
    output logic         push_rdy,
    input  logic [W-1:0] push_data,
    output logic         pop_val,
    input  logic         pop_rdy,
    output logic [W-1:0] pop_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          empty, full, wr_en, rd_en;

    function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty    = (count == '0);
    assign full     = (count == CW'(DEPTH));
    assign push_rdy = !full;
    assign rd_en    = pop_rdy && !empty;

    generate
        if (BYPASS) begin : g_bypass
            // an empty FIFO hands the incoming entry straight to its output
            assign pop_val  = !empty || push_val;
            assign pop_data = empty ? push_data : store[rd_ptr];
            assign wr_en    = push_val && !full && !(empty && pop_rdy);
        end else begin : g_plain
            assign pop_val  = !empty;
            assign pop_data = store[rd_ptr];
            assign wr_en    = push_val && !full;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= ptr_next(wr_ptr);
            if (rd_en) rd_ptr <= ptr_next(rd_ptr);
            count <= count + CW'(wr_en) - CW'(rd_en);
        end
    end
endmodule

// File: rtl/lsu_req_gen.sv
`timescale 1ns/1ps
module lsu_req_gen
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  lsu_op_e                       op,
    input  logic [DATA_W-1:0]             base,
    input  logic [DATA_W-1:0]             ofs,
    input  logic [DATA_W-1:0]             sdata,
    output logic [DATA_W-1:0]             addr,
    output logic                          we,
    output logic [DATA_W/8-1:0]           strb,
    output logic [DATA_W-1:0]             wdata,
    output logic [$clog2(DATA_W/8)-1:0]   byte_ofs
);
    localparam int STRB_W = DATA_W / 8;
    localparam int OFS_W  = $clog2(STRB_W);

    logic [DATA_W-1:0] eff;
    logic [OFS_W+2:0]  bit_sh;

    assign eff      = base + ofs;
    assign byte_ofs = eff[OFS_W-1:0];
    assign addr     = {eff[DATA_W-1:OFS_W], {OFS_W{1'b0}}};
    assign we       = op_is_store(op);
    assign bit_sh   = {byte_ofs, 3'b000};

    always_comb begin
        strb  = '0;
        wdata = '0;
        case (op)
            OP_SB: begin
                strb  = STRB_W'(1) << byte_ofs;
                wdata = DATA_W'(sdata[7:0]) << bit_sh;
            end
            OP_SH: begin
                strb  = STRB_W'(3) << byte_ofs;
                wdata = DATA_W'(sdata[15:0]) << bit_sh;
            end
            OP_SW: begin
                strb  = '1;
                wdata = sdata;
            end
            default: begin
                strb  = '0;
                wdata = '0;
            end
        endcase
    end
endmodule

// File: rtl/lsu_load_ext.sv
`timescale 1ns/1ps
module lsu_load_ext
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  lsu_op_e                     op,
    input  logic [$clog2(DATA_W/8)-1:0] byte_ofs,
    input  logic [DATA_W-1:0]           rdata,
    output logic [DATA_W-1:0]           result,
    output logic                        wen
);
    localparam int OFS_W = $clog2(DATA_W / 8);

    logic [DATA_W-1:0] lane;
    logic [OFS_W+2:0]  bit_sh;

    assign bit_sh = {byte_ofs, 3'b000};
    assign lane   = rdata >> bit_sh;
    assign wen    = !op_is_store(op);

    always_comb begin
        case (op)
            OP_LB:   result = {{(DATA_W-8){lane[7]}}, lane[7:0]};
            OP_LH:   result = {{(DATA_W-16){lane[15]}}, lane[15:0]};
            OP_LW:   result = lane;
            OP_LBU:  result = {{(DATA_W-8){1'b0}}, lane[7:0]};
            OP_LHU:  result = {{(DATA_W-16){1'b0}}, lane[15:0]};
            default: result = '0;
        endcase
    end
endmodule

// File: rtl/lsu_pipe.sv
`timescale 1ns/1ps
module lsu_pipe
    import lsu_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int SEQ_W        = 8,
    parameter int AREG_W       = 5,
    parameter int PREG_W       = 6,
    parameter int IN_DEPTH     = 2,
    parameter int MAX_INFLIGHT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_val,
    output logic                in_rdy,
    input  logic [2:0]          in_op,
    input  logic [SEQ_W-1:0]    in_seq,
    input  logic [AREG_W-1:0]   in_dst,
    input  logic [PREG_W-1:0]   in_preg,
    input  logic [PREG_W-1:0]   in_ppreg,
    input  logic [DATA_W-1:0]   in_base,
    input  logic [DATA_W-1:0]   in_ofs,
    input  logic [DATA_W-1:0]   in_sdata,
    output logic                mreq_val,
    input  logic                mreq_rdy,
    output logic                mreq_we,
    output logic [DATA_W-1:0]   mreq_addr,
    output logic [DATA_W-1:0]   mreq_wdata,
    output logic [DATA_W/8-1:0] mreq_strb,
    input  logic                mrsp_val,
    output logic                mrsp_rdy,
    input  logic [DATA_W-1:0]   mrsp_data,
    output logic                wb_val,
    input  logic                wb_rdy,
    output logic [SEQ_W-1:0]    wb_seq,
    output logic [AREG_W-1:0]   wb_dst,
    output logic [PREG_W-1:0]   wb_preg,
    output logic [PREG_W-1:0]   wb_ppreg,
    output logic                wb_wen,
    output logic [DATA_W-1:0]   wb_data
);
    localparam int OFS_W  = $clog2(DATA_W / 8);
    localparam int QDEPTH = 1 << $clog2(MAX_INFLIGHT);
    localparam int TAG_W  = SEQ_W + AREG_W + 2 * PREG_W;
    localparam int IN_W   = 3 + TAG_W + 3 * DATA_W;
    localparam int META_W = OFS_W + 3 + TAG_W;

    // ---------------- stage 1: input FIFO and request formation
    logic [IN_W-1:0]   in_word, head_word;
    logic              head_val, req_fire;
    logic [2:0]        h_op_raw;
    logic [TAG_W-1:0]  h_tag;
    logic [DATA_W-1:0] h_base, h_ofs, h_sdata;
    logic [OFS_W-1:0]  h_bofs;

    assign in_word = {in_op, in_seq, in_dst, in_preg, in_ppreg, in_base, in_ofs, in_sdata};

    lsu_fifo #(.W(IN_W), .DEPTH(IN_DEPTH), .BYPASS(1'b1)) u_in_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_val (in_val),
        .push_rdy (in_rdy),
        .push_data(in_word),
        .pop_val  (head_val),
        .pop_rdy  (req_fire),
        .pop_data (head_word)
    );

    assign {h_op_raw, h_tag, h_base, h_ofs, h_sdata} = head_word;

    lsu_req_gen #(.DATA_W(DATA_W)) u_req_gen (
        .op      (lsu_op_e'(h_op_raw)),
        .base    (h_base),
        .ofs     (h_ofs),
        .sdata   (h_sdata),
        .addr    (mreq_addr),
        .we      (mreq_we),
        .strb    (mreq_strb),
        .wdata   (mreq_wdata),
        .byte_ofs(h_bofs)
    );

    // ---------------- metadata queue
    logic [META_W-1:0] meta_new, q_head;
    logic              q_space, q_out_val, q_empty, q_push, q_pop;

    assign meta_new = {h_bofs, h_op_raw, h_tag};
    assign mreq_val = head_val && q_space;
    assign req_fire = mreq_val && mreq_rdy;

    lsu_fifo #(.W(META_W), .DEPTH(QDEPTH), .BYPASS(1'b0)) u_meta_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_val (q_push),
        .push_rdy (q_space),
        .push_data(meta_new),
        .pop_val  (q_out_val),
        .pop_rdy  (q_pop),
        .pop_data (q_head)
    );

    assign q_empty = !q_out_val;

    // ---------------- stage 2: awaited-response slot
    s2_state_e         state, state_nxt;
    logic [META_W-1:0] s2_meta;
    logic              rsp_fire, slot_free, take_bypass;

    assign mrsp_rdy    = (state == S2_WAIT) && wb_rdy;
    assign rsp_fire    = mrsp_val && mrsp_rdy;
    assign slot_free   = (state == S2_IDLE) || rsp_fire;
    assign q_pop       = slot_free && !q_empty;
    assign take_bypass = slot_free && q_empty && req_fire;
    assign q_push      = req_fire && !take_bypass;

    always_comb begin
        state_nxt = state;
        unique case (state)
            S2_IDLE: if (take_bypass) state_nxt = S2_WAIT;             // T_BYPASS
            S2_WAIT: if (rsp_fire)
                         state_nxt = (q_pop || take_bypass) ? S2_WAIT  // T_CHAIN
                                                            : S2_IDLE; // T_DRAIN
            default: state_nxt = S2_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S2_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (q_pop)            s2_meta <= q_head;
        else if (take_bypass) s2_meta <= meta_new;
    end

    // ---------------- stage 2 outputs
    logic [OFS_W-1:0] s2_bofs;
    logic [2:0]       s2_op_raw;

    assign {s2_bofs, s2_op_raw, wb_seq, wb_dst, wb_preg, wb_ppreg} = s2_meta;
    assign wb_val = (state == S2_WAIT) && mrsp_val;

    lsu_load_ext #(.DATA_W(DATA_W)) u_load_ext (
        .op      (lsu_op_e'(s2_op_raw)),
        .byte_ofs(s2_bofs),
        .rdata   (mrsp_data),
        .result  (wb_data),
        .wen     (wb_wen)
    );
endmodule

// File: rtl/lsu_pipe_chk.sv
`timescale 1ns/1ps
module lsu_pipe_chk
    import lsu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int QDEPTH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mreq_val,
    input logic                mreq_rdy,
    input logic                mreq_we,
    input logic [DATA_W-1:0]   mreq_addr,
    input logic [DATA_W/8-1:0] mreq_strb,
    input logic                mrsp_val,
    input logic                mrsp_rdy,
    input logic                wb_val,
    input logic                wb_rdy,
    input logic                wb_wen,
    input logic [DATA_W-1:0]   wb_data,
    input s2_state_e           s2_state,
    input logic                q_empty,
    input logic                q_space
);
    localparam int OFS_W = $clog2(DATA_W / 8);
    localparam int CW    = $clog2(QDEPTH + 2) + 1;

    logic [CW-1:0] outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) outstanding <= '0;
        else outstanding <= outstanding + CW'(mreq_val && mreq_rdy)
                                        - CW'(mrsp_val && mrsp_rdy);
    end

    p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_val |-> (mreq_addr[OFS_W-1:0] == '0));

    p_load_nostrb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_val && !mreq_we) |-> (mreq_strb == '0));

    p_store_strb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_val && mreq_we) |-> (mreq_strb != '0));

    p_need_space_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mreq_val |-> q_space);

    p_inflight_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= CW'(QDEPTH + 1));

    p_idle_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_state == S2_IDLE) |-> q_empty);

    p_bypass_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_val && mreq_rdy && outstanding == '0) |=> (s2_state == S2_WAIT));

    p_store_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_val && !wb_wen) |-> (wb_data == '0));

    p_rsp_needs_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mrsp_rdy |-> (wb_rdy && outstanding != '0));

    p_wb_needs_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_val |-> mrsp_val);
endmodule

bind lsu_pipe lsu_pipe_chk #(.DATA_W(DATA_W), .QDEPTH(QDEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mreq_val (mreq_val),
    .mreq_rdy (mreq_rdy),
    .mreq_we  (mreq_we),
    .mreq_addr(mreq_addr),
    .mreq_strb(mreq_strb),
    .mrsp_val (mrsp_val),
    .mrsp_rdy (mrsp_rdy),
    .wb_val   (wb_val),
    .wb_rdy   (wb_rdy),
    .wb_wen   (wb_wen),
    .wb_data  (wb_data),
    .s2_state (state),
    .q_empty  (q_empty),
    .q_space  (q_space)
);

// File: tb/sim_lsu_pipe.sv
`timescale 1ns/1ps
module sim_lsu_pipe;
    localparam int DATA_W = 32, SEQ_W = 8, AREG_W = 5, PREG_W = 6;
    localparam int NVEC = 17;
    localparam int HOLD = 20;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] base, ofs, sdata, addr;
        logic [3:0]  strb;
        logic [31:0] wdata, wb;
    } vec_t;

    // op codes: 0 LB 1 LH 2 LW 3 LBU 4 LHU 5 SB 6 SH 7 SW; every memory word starts at 80F17FA2
    localparam vec_t VEC [NVEC] = '{
        '{3'd2, 32'h100, 32'h4,        32'h0,        32'h104, 4'h0, 32'h0,        32'h80F17FA2},
        '{3'd0, 32'h100, 32'h0,        32'h0,        32'h100, 4'h0, 32'h0,        32'hFFFFFFA2},
        '{3'd0, 32'h100, 32'h1,        32'h0,        32'h100, 4'h0, 32'h0,        32'h0000007F},
        '{3'd3, 32'h100, 32'h2,        32'h0,        32'h100, 4'h0, 32'h0,        32'h000000F1},
        '{3'd0, 32'h100, 32'h3,        32'h0,        32'h100, 4'h0, 32'h0,        32'hFFFFFF80},
        '{3'd1, 32'h100, 32'h0,        32'h0,        32'h100, 4'h0, 32'h0,        32'h00007FA2},
        '{3'd1, 32'h100, 32'h2,        32'h0,        32'h100, 4'h0, 32'h0,        32'hFFFF80F1},
        '{3'd4, 32'h100, 32'h2,        32'h0,        32'h100, 4'h0, 32'h0,        32'h000080F1},
        '{3'd5, 32'h200, 32'h3,        32'h123456CD, 32'h200, 4'h8, 32'hCD000000, 32'h0},
        '{3'd2, 32'h200, 32'h0,        32'h0,        32'h200, 4'h0, 32'h0,        32'hCDF17FA2},
        '{3'd6, 32'h1FC, 32'hA,        32'hAAAA9876, 32'h204, 4'hC, 32'h98760000, 32'h0},
        '{3'd1, 32'h200, 32'h6,        32'h0,        32'h204, 4'h0, 32'h0,        32'hFFFF9876},
        '{3'd4, 32'h204, 32'h0,        32'h0,        32'h204, 4'h0, 32'h0,        32'h00007FA2},
        '{3'd7, 32'h300, 32'hFFFFFFFC, 32'h0BADF00D, 32'h2FC, 4'hF, 32'h0BADF00D, 32'h0},
        '{3'd3, 32'h2FF, 32'hFFFFFFFE, 32'h0,        32'h2FC, 4'h0, 32'h0,        32'h000000F0},
        '{3'd5, 32'h400, 32'h0,        32'h00000055, 32'h400, 4'h1, 32'h00000055, 32'h0},
        '{3'd0, 32'h400, 32'h0,        32'h0,        32'h400, 4'h0, 32'h0,        32'h00000055}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_val = 0, in_rdy;
    logic [2:0] in_op = 0;
    logic [SEQ_W-1:0] in_seq = 0;
    logic [AREG_W-1:0] in_dst = 0;
    logic [PREG_W-1:0] in_preg = 0, in_ppreg = 0;
    logic [DATA_W-1:0] in_base = 0, in_ofs = 0, in_sdata = 0;
    logic mreq_val, mreq_rdy = 0, mreq_we;
    logic [DATA_W-1:0] mreq_addr, mreq_wdata;
    logic [3:0] mreq_strb;
    logic mrsp_val = 0, mrsp_rdy;
    logic [DATA_W-1:0] mrsp_data = 0;
    logic wb_val, wb_rdy = 0, wb_wen;
    logic [SEQ_W-1:0] wb_seq;
    logic [AREG_W-1:0] wb_dst;
    logic [PREG_W-1:0] wb_preg, wb_ppreg;
    logic [DATA_W-1:0] wb_data;

    always #2.5 clk = ~clk;

    lsu_pipe u0 (.*);

    int checks = 0, failures = 0, cyc = 0, rel = 0;
    int issue_idx, req_idx, wb_idx, last_g, mode_g, rq_head, rq_tail, r9_bad = 0;
    logic [31:0] mem [256];
    logic [31:0] rq_data [64];
    int rq_due [64], in_cyc [NVEC], req_cyc [NVEC];
    bit done = 0;

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    function automatic logic [24:0] tag_of(int i);
        return {SEQ_W'(i + 16), AREG_W'(i + 1), PREG_W'(i + 3), PREG_W'(i + 9)};
    endfunction

    task automatic drive();
        in_val = issue_idx < last_g;
        if (in_val) begin
            in_op = VEC[issue_idx].op;
            in_base = VEC[issue_idx].base;
            in_ofs = VEC[issue_idx].ofs;
            in_sdata = VEC[issue_idx].sdata;
            {in_seq, in_dst, in_preg, in_ppreg} = tag_of(issue_idx);
        end
        mreq_rdy = (mode_g == 1) ? (cyc % 3 != 0) : 1'b1;
        wb_rdy   = (mode_g == 1) ? (cyc % 4 != 1) : 1'b1;
        mrsp_val = (rq_head < rq_tail) && (cyc >= rq_due[rq_head]) && !(mode_g == 2 && rel < HOLD);
        mrsp_data = (rq_head < rq_tail) ? rq_data[rq_head] : 32'h0;
    endtask

    task automatic step();
        bit inf, rqf, rsf, wbf;
        int w;
        @(negedge clk);
        if (mode_g == 2 && rel == HOLD) begin
            chk((rq_tail - rq_head) == 5, "R3 outstanding at stall", rq_tail - rq_head, 5);
            chk(!mreq_val, "R3 request withheld when queue full", mreq_val, 0);
            chk(issue_idx == 7, "R4 instructions accepted while stalled", issue_idx, 7);
            chk(!in_rdy, "R4 input ready low when FIFO full", in_rdy, 0);
        end
        inf = in_val && in_rdy;
        rqf = mreq_val && mreq_rdy;
        rsf = mrsp_val && mrsp_rdy;
        wbf = wb_val && wb_rdy;
        if ((mrsp_rdy && !wb_rdy) || (wb_val && !mrsp_val)) r9_bad++;
        if (inf) begin
            in_cyc[issue_idx] = cyc;
            issue_idx++;
        end
        if (rqf) begin
            vec_t v = VEC[req_idx];
            chk(mreq_addr == v.addr, $sformatf("R1 address of item %0d", req_idx), mreq_addr, v.addr);
            chk(mreq_strb == v.strb, $sformatf("R2 strobe of item %0d", req_idx), 32'(mreq_strb), 32'(v.strb));
            chk(mreq_we == (v.op >= 3'd5), $sformatf("R2 write flag of item %0d", req_idx), 32'(mreq_we), 32'(v.op >= 3'd5));
            if (v.op >= 3'd5)
                chk(mreq_wdata == v.wdata, $sformatf("R2 write data of item %0d", req_idx), mreq_wdata, v.wdata);
            if (mode_g == 0)
                chk(cyc == in_cyc[req_idx], $sformatf("R4 same-cycle issue of item %0d", req_idx), cyc, in_cyc[req_idx]);
            w = int'(mreq_addr[9:2]);
            for (int b = 0; b < 4; b++)
                if (mreq_strb[b]) mem[w][8*b +: 8] = mreq_wdata[8*b +: 8];
            rq_data[rq_tail] = mem[w];
            rq_due[rq_tail] = cyc + ((mode_g == 1) ? 4 : 1);
            rq_tail++;
            req_cyc[req_idx] = cyc;
            req_idx++;
        end
        if (rsf) rq_head++;
        if (wbf) begin
            vec_t v = VEC[wb_idx];
            chk(wb_data == v.wb, $sformatf("R6 R7 result of item %0d", wb_idx), wb_data, v.wb);
            chk(wb_wen == (v.op < 3'd5), $sformatf("R7 write enable of item %0d", wb_idx), 32'(wb_wen), 32'(v.op < 3'd5));
            chk({wb_seq, wb_dst, wb_preg, wb_ppreg} == tag_of(wb_idx), $sformatf("R8 tags of item %0d", wb_idx),
                32'({wb_seq, wb_dst, wb_preg, wb_ppreg}), 32'(tag_of(wb_idx)));
            if (mode_g == 0)
                chk(cyc == req_cyc[wb_idx] + 1, $sformatf("R5 turnaround of item %0d", wb_idx), cyc, req_cyc[wb_idx] + 1);
            wb_idx++;
        end
        @(posedge clk);
        cyc++;
        rel++;
        #1;
        drive();
    endtask

    task automatic run_seq(input int first, input int last, input int mode);
        issue_idx = first; req_idx = first; wb_idx = first;
        last_g = last; mode_g = mode; rq_head = 0; rq_tail = 0; rel = 0;
        drive();
        while (wb_idx < last) step();
        repeat (3) step();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h80F17FA2;
        issue_idx = 0; last_g = 0; mode_g = 0; rq_head = 0; rq_tail = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(in_rdy && !mreq_val && !mrsp_rdy && !wb_val, "R10 outputs during reset",
            {in_rdy, mreq_val, mrsp_rdy, wb_val}, 4'b1000);
        rst_n = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        chk(in_rdy && !mreq_val && !mrsp_rdy && !wb_val, "R10 outputs after reset",
            {in_rdy, mreq_val, mrsp_rdy, wb_val}, 4'b1000);
        @(posedge clk); #1;

        run_seq(0, NVEC, 0);   // table walk, quiet memory
        run_seq(0, NVEC, 1);   // table walk, backpressure and latency
        run_seq(0, 8, 2);      // responses withheld until queue fills
        run_seq(9, 10, 0);     // lone instruction through the bypass slot

        chk(r9_bad == 0, "R9 response ready and result valid coupling", r9_bad, 0);
        done = 1;
        report();
        $finish;
    end

    always @(posedge clk) begin
        if (!done && cyc > 20000) begin
            failures++;
            checks++;
            $display("FAIL watchdog R10 run hung actual=%0d expected=%0d", cyc, 20000);
            report();
            $finish;
        end
    end
endmodule